// File: doc/BRIEF.md
# Banked GPIO Interrupt and Wake Detector

This block turns the filtered, synchronised levels of a set of GPIO pins into latched interrupt and wake requests. Pins are grouped into banks of 32, one register word per bank for each register class. For every pin, software chooses between edge detection and level detection. In edge mode a pin can trigger on rising edges, falling edges or both. In level mode the pin is active-high or active-low. A detection event latches a per-pin interrupt status bit and, in parallel, a per-pin wake status bit. Both are cleared by writing ones.

The interrupt output is high while any bank has a status bit whose mask bit is set. The wake output is high while any wake status bit has its wake mask bit set. Register writes arrive as single-cycle strobes with a byte address. A combinational read port returns any register word. Both ports are plain control paths with no handshake: a write strobe always completes in the cycle it is presented.

The address map is byte-addressed with a 4-byte stride per bank. The class bases are fixed, so the block supports up to six banks before one class would run into the next.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every configuration, status, wake mask and wake status word reads 0, and both `irq` and `wake` are low.
- R2: With input type 0 (edge mode) and rising enable set (class base 0x064, bank b at base+4b, bit i = pin 32b+i), a 0-to-1 change of the pin sets its status bit (class base 0x0C4) at the clock edge that samples the new level. A pin held steady does not set it again after a clear.
- R3: With falling enable set (class base 0x07C), a 1-to-0 change sets the status bit. A rising change does not, unless rising enable is also set. With both enables set, either change sets it.
- R4: With input type 1 (class base 0x300, 1 = level, 0 = edge), the status bit sets on every cycle the pin is at its active level. Polarity (class base 0x318) 0 means active-high and 1 means active-low.
- R5: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R6: A detection event in the same cycle as a clear leaves the status bit set. A clear of a level-mode bit whose pin is still active therefore does not take effect.
- R7: `irq` is the OR over all banks of status AND mask (class base 0x0AC, 1 = enabled). It follows mask and status changes in the cycle after the write or event.
- R8: Each detection event also sets the wake status bit (class base 0x418), whatever the interrupt mask holds. Wake status is cleared by writing 1, independently of interrupt status. `wake` is the OR of wake status AND wake mask (class base 0x400).
- R9: Configuration words read back what was written. Writes to addresses outside the map change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NBANK*32 | Filtered, synchronised pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Register word at rd_addr (combinational) |
| irq | output | 1 | Combined masked interrupt request |
| wake | output | 1 | Combined masked wake request |

## Verification
The bench builds the block with NBANK=2, so 64 pins spread over two register words per class. This brings the bank index decode within reach, as well as the second-word addresses of every class and the OR of interrupt and wake requests across banks. One interrupt is raised only from bank 1 while bank 0 is fully unmasked and idle. Level-mode and polarity cases run on bank 1 pins, and edge cases run on bank 0 pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int NUM_CLS = 8;

  typedef enum logic [3:0] {
    RC_NONE  = 4'd0,
    RC_RISE  = 4'd1,
    RC_FALL  = 4'd2,
    RC_MASK  = 4'd3,
    RC_STAT  = 4'd4,
    RC_TYPE  = 4'd5,
    RC_POL   = 4'd6,
    RC_WMASK = 4'd7,
    RC_WSTAT = 4'd8
  } reg_class_e;

  // byte offset of bank 0 for each class, in enum order starting at RC_RISE
  localparam int unsigned CLS_BASE [NUM_CLS] = '{
    32'h064, 32'h07C, 32'h0AC, 32'h0C4, 32'h300, 32'h318, 32'h400, 32'h418
  };

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int BIDX_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_class_e        cls,
  output logic [BIDX_W-1:0] bank
);

  always_comb begin
    int unsigned word_idx;
    word_idx = 32'(addr) >> 2;
    hit  = 1'b0;
    cls  = RC_NONE;
    bank = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if ((word_idx >= CLS_BASE[c] / 4) && (word_idx < CLS_BASE[c] / 4 + NBANK)) begin
        hit  = 1'b1;
        cls  = reg_class_e'(4'(c + 1));
        bank = BIDX_W'(word_idx - CLS_BASE[c] / 4);
      end
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] lvl_mode,
  input  logic [W-1:0] act_low,
  output logic [W-1:0] evt
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic edge_hit;
    logic level_hit;
    assign edge_hit  = (rise_en[i] & lvl[i] & ~prev_q[i]) |
                       (fall_en[i] & ~lvl[i] & prev_q[i]);
    assign level_hit = lvl[i] ^ act_low[i];
    assign evt[i]    = lvl_mode[i] ? level_hit : edge_hit;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_wr,
  input  reg_class_e   wr_cls,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] type_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] wmask_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] wstat_q,
  output logic [W-1:0] evt,
  output logic [W-1:0] clr,
  output logic         irq_any,
  output logic         wake_any
);

  logic [W-1:0] wclr;

  gpio_irq_detect #(.W(W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .lvl_mode (type_q),
    .act_low  (pol_q),
    .evt      (evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      mask_q  <= '0;
      type_q  <= '0;
      pol_q   <= '0;
      wmask_q <= '0;
    end else if (sel_wr) begin
      unique case (wr_cls)
        RC_RISE:  rise_q  <= wr_data;
        RC_FALL:  fall_q  <= wr_data;
        RC_MASK:  mask_q  <= wr_data;
        RC_TYPE:  type_q  <= wr_data;
        RC_POL:   pol_q   <= wr_data;
        RC_WMASK: wmask_q <= wr_data;
        default:  ;
      endcase
    end
  end

  assign clr  = (sel_wr && wr_cls == RC_STAT)  ? wr_data : '0;
  assign wclr = (sel_wr && wr_cls == RC_WSTAT) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      wstat_q <= '0;
    end else begin
      stat_q  <= (stat_q  & ~clr)  | evt;
      wstat_q <= (wstat_q & ~wclr) | evt;
    end
  end

  assign irq_any  = |(stat_q & mask_q);
  assign wake_any = |(wstat_q & wmask_q);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NBANK = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*WORD_W-1:0] pin_lvl,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [WORD_W-1:0]       rd_data,
  output logic                    irq,
  output logic                    wake
);

  localparam int W      = WORD_W;
  localparam int NPIN   = NBANK * W;
  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic              wr_hit, rd_hit;
  reg_class_e        wr_cls, rd_cls;
  logic [BIDX_W-1:0] wr_bank, rd_bank;

  logic [W-1:0] rise_b  [NBANK];
  logic [W-1:0] fall_b  [NBANK];
  logic [W-1:0] mask_b  [NBANK];
  logic [W-1:0] type_b  [NBANK];
  logic [W-1:0] pol_b   [NBANK];
  logic [W-1:0] wmask_b [NBANK];
  logic [W-1:0] stat_b  [NBANK];
  logic [W-1:0] wstat_b [NBANK];

  logic [NBANK-1:0] irq_bank, wake_bank;
  logic [NPIN-1:0]  evt_all, clr_all, stat_all, wstat_all;

  gpio_irq_decode #(.NBANK(NBANK), .BIDX_W(BIDX_W)) u_wdec (
    .addr (wr_addr),
    .hit  (wr_hit),
    .cls  (wr_cls),
    .bank (wr_bank)
  );

  gpio_irq_decode #(.NBANK(NBANK), .BIDX_W(BIDX_W)) u_rdec (
    .addr (rd_addr),
    .hit  (rd_hit),
    .cls  (rd_cls),
    .bank (rd_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = wr_en && wr_hit && (wr_bank == BIDX_W'(b));

    gpio_irq_bank #(.W(W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (sel),
      .wr_cls   (wr_cls),
      .wr_data  (wr_data),
      .lvl      (pin_lvl[b*W +: W]),
      .rise_q   (rise_b[b]),
      .fall_q   (fall_b[b]),
      .mask_q   (mask_b[b]),
      .type_q   (type_b[b]),
      .pol_q    (pol_b[b]),
      .wmask_q  (wmask_b[b]),
      .stat_q   (stat_b[b]),
      .wstat_q  (wstat_b[b]),
      .evt      (evt_all[b*W +: W]),
      .clr      (clr_all[b*W +: W]),
      .irq_any  (irq_bank[b]),
      .wake_any (wake_bank[b])
    );

    assign stat_all[b*W +: W]  = stat_b[b];
    assign wstat_all[b*W +: W] = wstat_b[b];
  end

  assign irq  = |irq_bank;
  assign wake = |wake_bank;

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      unique case (rd_cls)
        RC_RISE:  rd_data = rise_b[rd_bank];
        RC_FALL:  rd_data = fall_b[rd_bank];
        RC_MASK:  rd_data = mask_b[rd_bank];
        RC_STAT:  rd_data = stat_b[rd_bank];
        RC_TYPE:  rd_data = type_b[rd_bank];
        RC_POL:   rd_data = pol_b[rd_bank];
        RC_WMASK: rd_data = wmask_b[rd_bank];
        RC_WSTAT: rd_data = wstat_b[rd_bank];
        default:  rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NPIN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            irq,
  input logic            wake,
  input logic [NPIN-1:0] evt_all,
  input logic [NPIN-1:0] clr_all,
  input logic [NPIN-1:0] stat_all,
  input logic [NPIN-1:0] wstat_all
);

  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    // R6: an event sets status even when a clear arrives with it (covers R2..R4 detection)
    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_all[i] |=> stat_all[i]);

    // R5: a clear without an event empties the bit
    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all[i] && !evt_all[i]) |=> !stat_all[i]);

    // R5: without event or clear the bit keeps its value
    assert_status_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all[i] && !evt_all[i]) |=> $stable(stat_all[i]));

    // R8: the wake status latches on the same event
    assert_wake_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_all[i] |=> wstat_all[i]);
  end

  // R7: the interrupt can only rise after an event or a register write
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(|evt_all)) |=> !$rose(irq));

  // R8: the wake request can only rise after an event or a register write
  assert_wake_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(|evt_all)) |=> !$rose(wake));

endmodule

bind gpio_irq_unit gpio_irq_checker #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .irq       (irq),
  .wake      (wake),
  .evt_all   (evt_all),
  .clr_all   (clr_all),
  .stat_all  (stat_all),
  .wstat_all (wstat_all)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;

  localparam int NBANK = 2;
  localparam int NPIN  = NBANK * 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic [NPIN-1:0]   pin_lvl = '0;
  logic              wr_en = 1'b0;
  logic [11:0]       wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [11:0]       rd_addr = '0;
  logic [31:0]       rd_data;
  logic              irq, wake;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.NBANK(NBANK)) u0 (
    .clk (clk), .rst_n (rst_n), .pin_lvl (pin_lvl),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data), .irq (irq), .wake (wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk);
    pin_lvl[i] = v;
    @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h064, d); check("R1 rise", d, 0);
    rd(12'h0C8, d); check("R1 stat", d, 0);
    rd(12'h300, d); check("R1 type", d, 0);
    rd(12'h41C, d); check("R1 wstat", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 wake", {31'd0, wake}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(12'h064, 32'hA5A5_0F0F);
    rd(12'h064, d); check("R9 rise readback", d, 32'hA5A5_0F0F);
    wr(12'h31C, 32'h1234_5678);
    rd(12'h31C, d); check("R9 pol bank1 readback", d, 32'h1234_5678);
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h064, d); check("R9 unmapped write", d, 32'hA5A5_0F0F);
    rd(12'h200, d); check("R9 unmapped read", d, 0);
    check("R9 irq after unmapped", {31'd0, irq}, 0);
    wr(12'h064, 0);
    wr(12'h31C, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(12'h064, 32'h8);
    pin(3, 1'b1);
    rd(12'h0C4, d); check("R2 rising sets", d, 32'h8);
    pin(3, 1'b0);
    rd(12'h0C4, d); check("R2 falling ignored", d, 32'h8);
    wr(12'h0C4, 32'h0);
    rd(12'h0C4, d); check("R5 write zero", d, 32'h8);
    wr(12'h0C4, 32'h8);
    rd(12'h0C4, d); check("R5 write one clears", d, 0);
    pin(3, 1'b1);
    wr(12'h0C4, 32'h8);
    idle();
    rd(12'h0C4, d); check("R2 steady high no re-set", d, 0);
    pin(3, 1'b0);
    wr(12'h064, 0);
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    wr(12'h07C, 32'h60);
    wr(12'h064, 32'h40);
    pin(5, 1'b1);
    rd(12'h0C4, d); check("R3 fall-only ignores rise", d, 0);
    pin(5, 1'b0);
    rd(12'h0C4, d); check("R3 falling sets", d, 32'h20);
    pin(6, 1'b1);
    rd(12'h0C4, d); check("R3 both rise", d, 32'h60);
    wr(12'h0C4, 32'h60);
    pin(6, 1'b0);
    rd(12'h0C4, d); check("R3 both fall", d, 32'h40);
    wr(12'h0C4, 32'h40);
    wr(12'h064, 0);
    wr(12'h07C, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    pin(40, 1'b1);
    rd(12'h0C8, d); check("R4 edge mode no enable", d, 0);
    wr(12'h304, 32'h100);
    idle();
    rd(12'h0C8, d); check("R4 active-high level", d, 32'h100);
    wr(12'h0C8, 32'h100);
    rd(12'h0C8, d); check("R6 level clear while active", d, 32'h100);
    pin(40, 1'b0);
    rd(12'h0C8, d); check("R4 latched after release", d, 32'h100);
    wr(12'h0C8, 32'h100);
    idle();
    rd(12'h0C8, d); check("R4 inactive clear", d, 0);
    wr(12'h31C, 32'h200);
    wr(12'h304, 32'h300);
    idle();
    rd(12'h0C8, d); check("R4 active-low level", d, 32'h200);
    pin(41, 1'b1);
    wr(12'h0C8, 32'h200);
    idle();
    rd(12'h0C8, d); check("R4 active-low released", d, 0);
    wr(12'h304, 0);
    wr(12'h31C, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(12'h064, 32'h80);
    @(negedge clk);
    pin_lvl[7] = 1'b1;
    wr_en = 1'b1; wr_addr = 12'h0C4; wr_data = 32'h80;
    @(negedge clk);
    wr_en = 1'b0;
    rd(12'h0C4, d); check("R6 event beats clear", d, 32'h80);
    wr(12'h0C4, 32'h80);
    rd(12'h0C4, d); check("R6 later clear", d, 0);
    wr(12'h064, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(12'h068, 32'h4);
    pin(34, 1'b1);
    rd(12'h0C8, d); check("R2 bank1 rising", d, 32'h4);
    check("R7 masked off", {31'd0, irq}, 0);
    wr(12'h0AC, 32'hFFFF_FFFF);
    check("R7 bank0 mask idle", {31'd0, irq}, 0);
    wr(12'h0B0, 32'h4);
    check("R7 bank1 unmasked", {31'd0, irq}, 1);
    wr(12'h0B0, 32'h0);
    check("R7 remasked", {31'd0, irq}, 0);
    wr(12'h0B0, 32'h4);
    wr(12'h0C8, 32'h4);
    check("R7 cleared status", {31'd0, irq}, 0);
    wr(12'h0AC, 0);
    wr(12'h0B0, 0);
    wr(12'h068, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    rd(12'h41C, d); check("R8 wake latched while masked", d & 32'h4, 32'h4);
    check("R8 wake mask off", {31'd0, wake}, 0);
    wr(12'h404, 32'h4);
    check("R8 wake raised", {31'd0, wake}, 1);
    wr(12'h41C, 32'h4);
    rd(12'h41C, d); check("R8 wake status cleared", d & 32'h4, 0);
    check("R8 wake dropped", {31'd0, wake}, 0);
    wr(12'h404, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_readback();
    t_rise();
    t_fall_both();
    t_level();
    t_same_cycle();
    t_irq();
    t_wake();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule